// File: doc/BRIEF.md
# Selectable-source counter array timebase

This block is the shared 16-bit timebase of a peripheral counter array in a microcontroller-class subsystem. It counts upward from one of four sources chosen by software: the block clock divided by twelve (one machine cycle), the block clock divided by four, a single-cycle overflow pulse from a neighbouring timer, or falling edges on an external count pin. The external pin passes through a two-flop synchroniser and is sampled once every four clocks, so no more than one edge is taken in any eight clocks.

Software reaches four byte-wide registers through a simple port with a combinational read: a mode register, a control register and the two counter bytes. The control register holds a run bit and a sticky wrap flag; the mode register holds the source select, an interrupt enable for the wrap flag, a gate that suspends counting while the idle input is high, and a stored watchdog-enable bit that this block only keeps for a neighbouring unit.

Top module: `pca_timebase`

## Requirements
- R1: After reset all four registers read 0x00 and irq_o is 0.
- R2: Register addresses are 0 mode, 1 control, 2 counter low byte, 3 counter high byte. Mode bit 7 is the idle gate, bit 6 the watchdog enable, bits 2:1 the source select, bit 0 the wrap interrupt enable; mode bits 5:3 ignore writes and read 0. Control bit 7 is the wrap flag, bit 6 the run bit; control bits 5:0 ignore writes and read 0. Counter bytes read back what was written while the counter is stopped.
- R3: With source select 00 and the run bit set, the counter advances exactly once per 12 clk_i cycles.
- R4: With source select 01 and the run bit set, the counter advances exactly once per 4 clk_i cycles.
- R5: With source select 10 and the run bit set, the counter advances once for each clk_i cycle in which tmr_ovf_i is high.
- R6: With source select 11 and the run bit set, each falling edge of ext_cnt_i with both levels held at least 8 clocks advances the counter exactly once; for any stimulus, no two advances are fewer than 8 clocks apart.
- R7: With the run bit clear the counter holds its value.
- R8: With the idle gate set, the counter holds while idle_i is high; with the gate clear, idle_i has no effect on counting.
- R9: An advance from 0xFFFF gives 0x0000 and sets the wrap flag, which stays set until software writes 0 to control bit 7.
- R10: A software write of 1 to the wrap flag sets it; when a wrap and a software clear of the flag fall in the same cycle, the flag ends set.
- R11: irq_o equals the wrap flag when the interrupt enable is 1, and is 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also the divided count reference |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe for one cycle |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i, combinational |
| idle_i | input | 1 | Low-power idle state indication |
| tmr_ovf_i | input | 1 | Overflow pulse from the neighbouring timer |
| ext_cnt_i | input | 1 | Asynchronous external count pin |
| irq_o | output | 1 | Wrap interrupt request |

## Verification
A wrong prescaler phase or divider length shows as a counter delta over a fixed window that differs from the window divided by 12 or 4, visible at the next counter read. A stuck edge-detect level shows as a missing or doubled count within 16 clocks of a slow pin edge, and a flag update lost to the same-cycle software clear shows on the control read and irq_o in the cycle after the wrap. Random windows of mixed sources, gate and idle settings compare each delta with a count computed from the requirements alone.

// File: rtl/pca_pkg.sv
package pca_pkg;
  typedef enum logic [1:0] {
    SRC_DIV12 = 2'b00,
    SRC_DIV4  = 2'b01,
    SRC_TMR   = 2'b10,
    SRC_EXT   = 2'b11
  } cnt_src_e;

  localparam int unsigned REG_MODE = 0;
  localparam int unsigned REG_CTRL = 1;
  localparam int unsigned REG_CNT0 = 2;
endpackage

// File: rtl/pca_prescaler.sv
module pca_prescaler #(
  parameter int unsigned FAST_DIV  = 4,
  parameter int unsigned SLOW_MULT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fast_tick_o,
  output logic slow_tick_o
);
  localparam int unsigned FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam int unsigned SW = (SLOW_MULT > 1) ? $clog2(SLOW_MULT) : 1;

  logic [FW-1:0] fast_q;
  logic [SW-1:0] slow_q;

  assign fast_tick_o = (fast_q == FW'(FAST_DIV - 1));
  assign slow_tick_o = fast_tick_o && (slow_q == SW'(SLOW_MULT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q <= '0;
      slow_q <= '0;
    end else begin
      fast_q <= fast_tick_o ? '0 : fast_q + FW'(1);
      if (fast_tick_o)
        slow_q <= slow_tick_o ? '0 : slow_q + SW'(1);
    end
  end
endmodule

// File: rtl/pca_ext_edge.sv
module pca_ext_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic sample_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level_q;
  logic                   pin_s;

  assign pin_s  = sync_q[SYNC_STAGES-1];
  // one edge needs a high sample then a low sample, so two sample periods apart
  assign fall_o = sample_i && level_q && !pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '1;
      level_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      if (sample_i) level_q <= pin_s;
    end
  end
endmodule

// File: rtl/pca_counter.sv
module pca_counter #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_BYTES = 2,
  localparam int unsigned CNT_W    = DATA_W * CNT_BYTES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 inc_i,
  input  logic [CNT_BYTES-1:0] byte_we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;

  // a software byte write takes the whole cycle, no advance
  assign step    = inc_i && !(|byte_we_i);
  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign wrap_o  = step && (&cnt_q);
  assign cnt_o   = cnt_q;

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cnt_q[b*DATA_W +: DATA_W] <= '0;
      else if (byte_we_i[b])
        cnt_q[b*DATA_W +: DATA_W] <= wdata_i;
      else if (step)
        cnt_q[b*DATA_W +: DATA_W] <= cnt_nxt[b*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pca_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_BYTES = 2,
  localparam int unsigned ADDR_W   = $clog2(REG_CNT0 + CNT_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              idle_i,
  input  logic              tmr_ovf_i,
  input  logic              ext_cnt_i,
  output logic              irq_o
);
  localparam int unsigned CNT_W    = DATA_W * CNT_BYTES;
  localparam int unsigned HI_BIT   = DATA_W - 1;
  localparam int unsigned NEXT_BIT = DATA_W - 2;

  logic     idle_gate_q, wdog_en_q, irq_en_q;
  cnt_src_e src_q;
  logic     flag_q, run_q;

  logic mode_we, ctrl_we;
  logic [CNT_BYTES-1:0] byte_we;
  logic tick4, tick12, ext_fall;
  logic src_tick, inc, wrap;
  logic [CNT_W-1:0] cnt;

  assign mode_we = wr_en_i && (addr_i == ADDR_W'(REG_MODE));
  assign ctrl_we = wr_en_i && (addr_i == ADDR_W'(REG_CTRL));

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_we
    assign byte_we[b] = wr_en_i && (addr_i == ADDR_W'(REG_CNT0 + b));
  end

  pca_prescaler #(.FAST_DIV(4), .SLOW_MULT(3)) u_presc (
    .clk_i, .rst_ni,
    .fast_tick_o(tick4),
    .slow_tick_o(tick12)
  );

  pca_ext_edge #(.SYNC_STAGES(2)) u_edge (
    .clk_i, .rst_ni,
    .pin_i   (ext_cnt_i),
    .sample_i(tick4),
    .fall_o  (ext_fall)
  );

  always_comb begin
    unique case (src_q)
      SRC_DIV12: src_tick = tick12;
      SRC_DIV4:  src_tick = tick4;
      SRC_TMR:   src_tick = tmr_ovf_i;
      default:   src_tick = ext_fall;
    endcase
  end

  assign inc = src_tick && run_q && !(idle_gate_q && idle_i);

  pca_counter #(.DATA_W(DATA_W), .CNT_BYTES(CNT_BYTES)) u_cnt (
    .clk_i, .rst_ni,
    .inc_i    (inc),
    .byte_we_i(byte_we),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_gate_q <= 1'b0;
      wdog_en_q   <= 1'b0;
      src_q       <= SRC_DIV12;
      irq_en_q    <= 1'b0;
    end else if (mode_we) begin
      idle_gate_q <= wdata_i[HI_BIT];
      wdog_en_q   <= wdata_i[NEXT_BIT];
      src_q       <= cnt_src_e'(wdata_i[2:1]);
      irq_en_q    <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (ctrl_we) run_q <= wdata_i[NEXT_BIT];
      // hardware wrap beats a same-cycle software clear
      if (wrap)         flag_q <= 1'b1;
      else if (ctrl_we) flag_q <= wdata_i[HI_BIT];
    end
  end

  assign irq_o = flag_q && irq_en_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_MODE)) begin
      rdata_o[HI_BIT]   = idle_gate_q;
      rdata_o[NEXT_BIT] = wdog_en_q;
      rdata_o[2:1]      = src_q;
      rdata_o[0]        = irq_en_q;
    end else if (addr_i == ADDR_W'(REG_CTRL)) begin
      rdata_o[HI_BIT]   = flag_q;
      rdata_o[NEXT_BIT] = run_q;
    end
    for (int b = 0; b < int'(CNT_BYTES); b++) begin
      if (addr_i == ADDR_W'(REG_CNT0 + b)) rdata_o = cnt[b*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/pca_timebase_chk.sv
module pca_timebase_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              idle_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              flag_i,
  input logic              run_i,
  input logic              idle_gate_i,
  input logic              irq_en_i,
  input logic              ext_fall_i
);
  logic [2:0] gap_q;
  logic       ctrl_wr;

  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gap_q <= 3'd7;
    else if (ext_fall_i) gap_q <= 3'd0;
    else if (gap_q != 3'd7) gap_q <= gap_q + 3'd1;
  end

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + CNT_W'(1)));

  p_run_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_en_i) |=> $stable(cnt_i));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_gate_i && idle_i && !wr_en_i) |=> $stable(cnt_i));

  p_wrap_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && (&cnt_i)) |=> (cnt_i != '0) || flag_i);

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !ctrl_wr) |=> flag_i);

  p_ext_rate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_fall_i |-> (gap_q == 3'd7));

  p_irq_mask_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (irq_en_i && flag_i));
endmodule

bind pca_timebase pca_timebase_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .idle_i     (idle_i),
  .irq_o      (irq_o),
  .cnt_i      (cnt),
  .flag_i     (flag_q),
  .run_i      (run_q),
  .idle_gate_i(idle_gate_q),
  .irq_en_i   (irq_en_q),
  .ext_fall_i (ext_fall)
);

// File: tb/pca_timebase_bench.sv
module pca_timebase_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       idle = 1'b0;
  logic       tmr_ovf = 1'b0;
  logic       ext_cnt = 1'b1;
  logic       irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pca_timebase u_pca_timebase (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .idle_i(idle), .tmr_ovf_i(tmr_ovf),
    .ext_cnt_i(ext_cnt), .irq_o(irq)
  );

  function automatic logic [7:0] mode_val(bit gate, bit [1:0] src, bit en);
    return {gate, 1'b0, 3'b000, src, en};
  endfunction

  function automatic int exp_delta(bit [1:0] src, int cycles, bit run, bit gate, bit idl);
    if (!run || (gate && idl)) return 0;
    return (src == 2'b00) ? cycles / 12 : cycles / 4;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_cnt(output int v);
    logic [7:0] lo, hi;
    rd(2'd2, lo);
    v = 0;
    hi = 8'h00;
    // high byte is read on the very next cycle, callers keep the counter idle or account for it
    rd(2'd3, hi);
    v = {hi, lo};
  endtask

  // counter delta over exactly n clocks, sampled from the low byte only
  task automatic window(int n, output int delta);
    logic [7:0] a, b;
    rd(2'd2, a);
    repeat (n - 1) @(negedge clk);
    rd(2'd2, b);
    delta = int'(8'(b - a));
  endtask

  task automatic pulse_ovf();
    @(negedge clk); tmr_ovf = 1'b1;
    @(posedge clk); #1 tmr_ovf = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int v, dl;
    void'($urandom(32'h5eed_0b5e));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reg", d, 0);
    end
    check("R1 irq", irq, 0);

    // R2 reserved bits and map
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R2 mode reserved", d, 8'hC7);
    wr(2'd1, 8'h3F);
    rd(2'd1, d); check("R2 ctrl reserved", d, 8'h00);
    wr(2'd0, 8'h00);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] lo, hi;
      lo = 8'($urandom); hi = 8'($urandom);
      wr(2'd2, lo); wr(2'd3, hi);
      rd_cnt(v);
      check("R2 count readback", v, {hi, lo});
    end

    // R3 machine-cycle source
    wr(2'd0, mode_val(0, 2'b00, 0));
    wr(2'd1, 8'h40);
    window(120, dl); check("R3 div12", dl, 10);
    // R4 quarter source
    wr(2'd0, mode_val(0, 2'b01, 0));
    window(100, dl); check("R4 div4", dl, 25);
    // R8 idle gating
    idle = 1'b1;
    window(64, dl); check("R8 gate clear idle", dl, 16);
    wr(2'd0, mode_val(1, 2'b01, 0));
    window(64, dl); check("R8 gate set idle", dl, 0);
    idle = 1'b0;
    window(64, dl); check("R8 gate set awake", dl, 16);
    // R7 stopped
    wr(2'd1, 8'h00);
    window(60, dl); check("R7 run clear", dl, 0);

    // R5 neighbour overflow pulses
    wr(2'd0, mode_val(0, 2'b10, 0));
    wr(2'd1, 8'h40);
    rd(2'd2, d); v = d;
    for (int i = 0; i < 7; i++) begin
      pulse_ovf();
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end
    rd(2'd2, d); check("R5 pulses", int'(8'(d - 8'(v))), 7);

    // R6 external pin, slow edges
    wr(2'd0, mode_val(0, 2'b11, 0));
    repeat (16) @(negedge clk);
    rd(2'd2, d); v = d;
    for (int i = 0; i < 5; i++) begin
      ext_cnt = 1'b0; repeat (8) @(negedge clk);
      ext_cnt = 1'b1; repeat (8) @(negedge clk);
    end
    repeat (16) @(negedge clk);
    rd(2'd2, d); check("R6 slow edges", int'(8'(d - 8'(v))), 5);
    // R6 too-fast toggling is rate limited
    v = d;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); ext_cnt = ~ext_cnt;
    end
    ext_cnt = 1'b1;
    repeat (16) @(negedge clk);
    rd(2'd2, d);
    check("R6 rate limit", (int'(8'(d - 8'(v))) <= 218 / 8) ? 1 : 0, 1);

    // R9 wrap and sticky flag, R11 masking
    wr(2'd0, mode_val(0, 2'b10, 0));
    wr(2'd2, 8'hFE); wr(2'd3, 8'hFF);
    pulse_ovf(); pulse_ovf();
    rd_cnt(v); check("R9 wrap value", v, 0);
    rd(2'd1, d); check("R9 flag set", d, 8'hC0);
    check("R11 irq masked", irq, 0);
    wr(2'd0, mode_val(0, 2'b10, 1));
    @(negedge clk); check("R11 irq enabled", irq, 1);
    pulse_ovf();
    rd(2'd1, d); check("R9 flag sticky", d, 8'hC0);
    wr(2'd1, 8'h40);
    rd(2'd1, d); check("R9 flag cleared", d, 8'h40);
    check("R11 irq follows clear", irq, 0);

    // R10 software set, and wrap beats same-cycle clear
    wr(2'd1, 8'h80);
    rd(2'd1, d); check("R10 sw set", d, 8'h80);
    check("R11 irq on sw set", irq, 1);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    wr(2'd1, 8'h40);
    @(negedge clk);
    addr = 2'd1; wdata = 8'h40; wr_en = 1'b1; tmr_ovf = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; tmr_ovf = 1'b0;
    rd(2'd1, d); check("R10 hw wins", d, 8'hC0);
    rd_cnt(v); check("R10 wrap count", v, 0);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);

    // random windows on the prescaled sources (R3 R4 R7 R8)
    for (int i = 0; i < 24; i++) begin
      bit [1:0] src;
      bit run, gate, idl;
      int cyc;
      src  = 2'($urandom_range(0, 1));
      run  = 1'($urandom);
      gate = 1'($urandom);
      idl  = 1'($urandom);
      cyc  = 12 * $urandom_range(1, 5);
      wr(2'd0, mode_val(gate, src, 0));
      wr(2'd1, {1'b0, run, 6'b0});
      idle = idl;
      window(cyc, dl);
      check("R3 R4 R7 R8 random window", dl, exp_delta(src, cyc, run, gate, idl));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule